// File: doc/BRIEF.md
# Mailbox Command Handshake Engine

This block is the host-side sequencer for a command mailbox held in a 32-bit word register space. The mailbox is sixteen consecutive words. Word 0 is a flag word that the host and the far side use to hand control back and forth. Word 1 holds the command code, word 2 is left to the far side for a return value, word 3 holds a timeout, and words 4 to 15 carry up to twelve argument words. One request, made up of a code, a timeout, an argument count and the argument words, is accepted while the engine is idle. The engine then runs the whole exchange on a simple word read/write bus without further help.

The exchange has a fixed order. First the parameters are written: code, timeout, then all twelve argument slots, with unused slots written as zero. The flag word is then raised to the driver pattern. The flag word is polled until the far side's completion bit appears. All sixteen words are then read back, and the flag word is written to zero. A far side that never completes is caught by a programmable poll limit. When the limit is reached the exchange stops with a hang error, and the flag word is left as it was. At the end of a normal exchange the readback words are presented along with a per-word mask of words that differ from what the engine expected to find.

Top module: `mbox_handshake_engine`

## Requirements
- R1: After a request is accepted, the first bus operations are writes, in order, to mailbox offsets 1 (code), 3 (timeout), then 4 through 15 (arguments). Offset 2 is never written. Offset 0 is not touched before all of these writes have completed.
- R2: Argument slot k (offset 4+k) receives argument word k when k is less than the request's argument count. Otherwise it receives zero. Argument word k sits at bits [32k+31:32k] of the argument input.
- R3: Right after the parameter writes, the flag word (offset 0) is written with 0x3, which is the driver-done and driver-busy bits.
- R4: The engine then reads offset 0 repeatedly. A read with bit 2 clear means the command is still running. The first read with bit 2 set ends polling.
- R5: Once completion is seen, offsets 0 through 15 are read in ascending order. The readback output holds word k at bits [32k+31:32k].
- R6: After the readback, the engine writes zero to offset 0. `done` then pulses high for one cycle with `hang_err` low.
- R7: The readback mismatch mask has bit k set when word k differs from what was written. For word 0 the comparison value is 0x7. Bit 2 (the return value word) is always clear.
- R8: With poll limit L (a value of 0 acts as 1), L consecutive poll reads with bit 2 clear end the exchange. `done` pulses with `hang_err` high, no further bus operation is issued, and the flag word keeps 0x3. When completion comes on read L, the exchange succeeds.
- R9: `busy` is high from the cycle after acceptance, through every bus operation, until the final flag clear or the abort. It falls in the same cycle that `done` rises.
- R10: A request presented while `busy` is high is ignored. The running exchange is unchanged and no second exchange follows.
- R11: A bus request holds its address, direction and write data steady until `bus_ack` is seen. Exactly one operation completes per acknowledged cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_code | input | 32 | Command code |
| req_timeout | input | 32 | Timeout word |
| req_argc | input | 4 | Number of argument words used (0 to 12) |
| req_args | input | 384 | Argument words, word k at bits [32k+31:32k] |
| poll_limit | input | 16 | Poll read limit, kept stable while busy |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| hang_err | output | 1 | Last exchange aborted on the poll limit |
| rb_data | output | 512 | Readback words, word k at bits [32k+31:32k] |
| rb_mismatch | output | 16 | Per-word readback mismatch mask |
| bus_req | output | 1 | Bus operation request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Word address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Operation complete |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The bench targets the poll boundary. Completion arrives exactly on the last allowed read, and is then withheld for one more. An off-by-one in the limit would hang a good exchange or let a stalled one run on, and either mistake shows up in the count of flag reads and in `hang_err`. A limit of zero must still allow one read. A design that skips the skip over offset 2, or that fails to zero-fill unused argument slots, leaves the wrong contents in the far side's mailbox. A compare that does not mask the return word reports a false mismatch on every exchange, because the far side writes its own value there. The bench also issues a second request in the middle of an exchange. A design that accepts it would overwrite the code word or start a second exchange.

// File: rtl/mbox_pkg.sv
// Shared constants and the sequencer state type for the mailbox engine.
// Assumes a 16-word mailbox with the flag word at offset 0.
package mbox_pkg;

    localparam int MBX_WORDS = 16;
    localparam int OFS_FLAG  = 0;
    localparam int OFS_CODE  = 1;
    localparam int OFS_RET   = 2;
    localparam int OFS_TMO   = 3;
    localparam int OFS_ARG0  = 4;

    // driver-done | driver-busy, and the pattern with firmware-done added
    localparam logic [2:0] FLAG_RAISE    = 3'b011;
    localparam int         FLAG_FW_BIT   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WPARM,
        ST_WFLAG,
        ST_POLL,
        ST_RDALL,
        ST_CLEAR
    } mbx_state_e;

endpackage

// File: rtl/mbox_image.sv
// Latches the 16-word mailbox image when a request is accepted.
// Word 0 holds the flag-raise pattern, word 2 is zero (never written),
// argument slots at or beyond the argument count are zero-filled.
module mbox_image
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NARGS  = 12,
    parameter int ARGC_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [DATA_W-1:0]         code,
    input  logic [DATA_W-1:0]         timeout,
    input  logic [ARGC_W-1:0]         argc,
    input  logic [NARGS*DATA_W-1:0]   args,
    output logic [MBX_WORDS*DATA_W-1:0] img
);

    // Fixed words of the image.
    assign img[OFS_FLAG*DATA_W +: DATA_W] = DATA_W'(FLAG_RAISE);
    assign img[OFS_RET*DATA_W  +: DATA_W] = '0;

    // Holds code and timeout words of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img[OFS_CODE*DATA_W +: DATA_W] <= '0;
            img[OFS_TMO*DATA_W  +: DATA_W] <= '0;
        end else if (load) begin
            img[OFS_CODE*DATA_W +: DATA_W] <= code;
            img[OFS_TMO*DATA_W  +: DATA_W] <= timeout;
        end
    end

    for (genvar j = 0; j < NARGS; j++) begin : g_arg
        // Holds one argument slot, zero when beyond the argument count.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                img[(OFS_ARG0+j)*DATA_W +: DATA_W] <= '0;
            end else if (load) begin
                img[(OFS_ARG0+j)*DATA_W +: DATA_W] <=
                    (ARGC_W'(j) < argc) ? args[j*DATA_W +: DATA_W] : '0;
            end
        end
    end

endmodule

// File: rtl/mbox_poll_guard.sv
// Counts flag polls that find the far side still working and flags the
// poll that reaches the limit. A limit of zero behaves as one.
// Assumes the limit is stable while polling.
module mbox_poll_guard #(
    parameter int PLIM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              polling,
    input  logic              miss,
    input  logic [PLIM_W-1:0] limit,
    output logic              expire
);

    logic [PLIM_W-1:0] cnt;
    logic [PLIM_W-1:0] lim_eff;
    logic [PLIM_W:0]   next_cnt;

    // Effective limit and the count this miss would reach.
    always_comb begin
        lim_eff  = (limit == '0) ? PLIM_W'(1) : limit;
        next_cnt = {1'b0, cnt} + 1'b1;
        expire   = miss && (next_cnt >= {1'b0, lim_eff});
    end

    // Miss counter, cleared per exchange, frozen at the aborting miss.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (miss && !expire) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_POLL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        polling |-> (cnt < lim_eff)); // R8

endmodule

// File: rtl/mbox_capture.sv
// Stores each readback word and compares it with the written image.
// The flag word is compared against the raise pattern plus the
// completion bit; the return-value word never reports a mismatch.
module mbox_capture
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        cap_en,
    input  logic [IDX_W-1:0]            cap_idx,
    input  logic [DATA_W-1:0]           cap_data,
    input  logic [MBX_WORDS*DATA_W-1:0] img,
    output logic [MBX_WORDS*DATA_W-1:0] rb_data,
    output logic [MBX_WORDS-1:0]        rb_mismatch
);

    for (genvar k = 0; k < MBX_WORDS; k++) begin : g_word
        logic [DATA_W-1:0] exp_w;

        // Expected readback value for this word.
        always_comb begin
            exp_w = img[k*DATA_W +: DATA_W];
            if (k == OFS_FLAG) exp_w[FLAG_FW_BIT] = 1'b1;
        end

        // Captures the word and its mismatch bit on its readback.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rb_data[k*DATA_W +: DATA_W] <= '0;
                rb_mismatch[k]              <= 1'b0;
            end else if (clr) begin
                rb_mismatch[k]              <= 1'b0;
            end else if (cap_en && cap_idx == IDX_W'(k)) begin
                rb_data[k*DATA_W +: DATA_W] <= cap_data;
                rb_mismatch[k]              <= (cap_data != exp_w) && (k != OFS_RET);
            end
        end
    end

endmodule

// File: rtl/mbox_seq.sv
// Sequencer for one mailbox exchange: parameter writes, flag raise,
// bounded polling, full readback, flag clear. Drives the word bus and
// holds each operation until it is acknowledged.
module mbox_seq
    import mbox_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter int                ADDR_W = 16,
    parameter int                IDX_W  = 4,
    parameter logic [ADDR_W-1:0] BASE   = 16'h0044
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [MBX_WORDS*DATA_W-1:0] img,
    input  logic                        fw_done,
    input  logic                        expire,
    input  logic                        bus_ack,
    output logic                        load,
    output logic                        busy,
    output logic                        done,
    output logic                        hang_err,
    output logic                        guard_clr,
    output logic                        polling,
    output logic                        poll_miss,
    output logic                        cap_en,
    output logic [IDX_W-1:0]            idx,
    output logic                        bus_req,
    output logic                        bus_we,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic [DATA_W-1:0]           bus_wdata
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MBX_WORDS - 1);

    mbx_state_e       state;
    logic [IDX_W-1:0] ofs;

    // Decodes control strobes for the sibling blocks.
    always_comb begin
        busy      = (state != ST_IDLE);
        load      = (state == ST_IDLE) && req_valid;
        guard_clr = (state == ST_WFLAG);
        polling   = (state == ST_POLL);
        poll_miss = polling && bus_ack && !fw_done;
        cap_en    = (state == ST_RDALL) && bus_ack;
    end

    // Drives the current bus operation from the state and index.
    always_comb begin
        bus_req   = busy;
        bus_we    = (state == ST_WPARM) || (state == ST_WFLAG) || (state == ST_CLEAR);
        ofs       = (state == ST_WPARM || state == ST_RDALL) ? idx : IDX_W'(OFS_FLAG);
        bus_addr  = BASE + ADDR_W'(ofs);
        unique case (state)
            ST_WPARM: bus_wdata = img[idx*DATA_W +: DATA_W];
            ST_WFLAG: bus_wdata = DATA_W'(FLAG_RAISE);
            default:  bus_wdata = '0;
        endcase
    end

    // Advances the exchange on each acknowledged operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            done     <= 1'b0;
            hang_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    state    <= ST_WPARM;
                    idx      <= IDX_W'(OFS_CODE);
                    hang_err <= 1'b0;
                end
                ST_WPARM: if (bus_ack) begin
                    if (idx == IDX_LAST)               state <= ST_WFLAG;
                    else if (idx == IDX_W'(OFS_CODE))  idx   <= IDX_W'(OFS_TMO);
                    else                               idx   <= idx + 1'b1;
                end
                ST_WFLAG: if (bus_ack) state <= ST_POLL;
                ST_POLL: if (bus_ack) begin
                    if (fw_done) begin
                        state <= ST_RDALL;
                        idx   <= '0;
                    end else if (expire) begin
                        state    <= ST_IDLE;
                        done     <= 1'b1;
                        hang_err <= 1'b1;
                    end
                end
                ST_RDALL: if (bus_ack) begin
                    if (idx == IDX_LAST) state <= ST_CLEAR;
                    else                 idx   <= idx + 1'b1;
                end
                ST_CLEAR: if (bus_ack) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_FLAG_AFTER_PARAMS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WFLAG && $past(state) != ST_WFLAG)
            |-> ($past(state) == ST_WPARM && $past(idx) == IDX_LAST)); // R1

    AST_FLAG_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL && $past(state) == ST_WFLAG)
            |-> $past(bus_ack && bus_we && bus_wdata[2:0] == FLAG_RAISE)); // R3

    AST_COMPLETE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDALL && $past(state) == ST_POLL) |-> $past(fw_done)); // R4

    AST_CLEAR_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hang_err)
            |-> $past(bus_ack && bus_we && bus_addr == BASE && bus_wdata == '0)); // R6

    AST_HANG_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hang_err) |-> ($past(state) == ST_POLL && !busy)); // R8

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack)
            |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata))); // R11

endmodule

// File: rtl/mbox_handshake_engine.sv
// Top of the mailbox command handshake engine. Wires the image latch,
// sequencer, poll guard and readback capture together.
// Assumes a single outstanding bus operation and a stable poll limit
// while busy.
module mbox_handshake_engine
    import mbox_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter int                ADDR_W = 16,
    parameter int                PLIM_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h0044
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [DATA_W-1:0]           req_code,
    input  logic [DATA_W-1:0]           req_timeout,
    input  logic [3:0]                  req_argc,
    input  logic [12*DATA_W-1:0]        req_args,
    input  logic [PLIM_W-1:0]           poll_limit,
    output logic                        busy,
    output logic                        done,
    output logic                        hang_err,
    output logic [16*DATA_W-1:0]        rb_data,
    output logic [15:0]                 rb_mismatch,
    output logic                        bus_req,
    output logic                        bus_we,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic [DATA_W-1:0]           bus_wdata,
    input  logic                        bus_ack,
    input  logic [DATA_W-1:0]           bus_rdata
);

    localparam int NARGS  = MBX_WORDS - OFS_ARG0;
    localparam int IDX_W  = $clog2(MBX_WORDS);
    localparam int ARGC_W = $clog2(NARGS + 1);

    logic                        load;
    logic [MBX_WORDS*DATA_W-1:0] img;
    logic                        guard_clr;
    logic                        polling;
    logic                        poll_miss;
    logic                        expire;
    logic                        cap_en;
    logic [IDX_W-1:0]            idx;
    logic                        fw_done;

    assign fw_done = bus_rdata[FLAG_FW_BIT];

    mbox_image #(.DATA_W(DATA_W), .NARGS(NARGS), .ARGC_W(ARGC_W)) u_image (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .code    (req_code),
        .timeout (req_timeout),
        .argc    (req_argc),
        .args    (req_args),
        .img     (img)
    );

    mbox_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .img       (img),
        .fw_done   (fw_done),
        .expire    (expire),
        .bus_ack   (bus_ack),
        .load      (load),
        .busy      (busy),
        .done      (done),
        .hang_err  (hang_err),
        .guard_clr (guard_clr),
        .polling   (polling),
        .poll_miss (poll_miss),
        .cap_en    (cap_en),
        .idx       (idx),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    mbox_poll_guard #(.PLIM_W(PLIM_W)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (guard_clr),
        .polling (polling),
        .miss    (poll_miss),
        .limit   (poll_limit),
        .expire  (expire)
    );

    mbox_capture #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (load),
        .cap_en      (cap_en),
        .cap_idx     (idx),
        .cap_data    (bus_rdata),
        .img         (img),
        .rb_data     (rb_data),
        .rb_mismatch (rb_mismatch)
    );

    AST_ACCEPT_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> (busy || done)); // R10

endmodule

// File: tb/mbox_handshake_engine_bench.sv
// Directed bench: a far-side mailbox model answers the bus; each task
// runs one scenario and checks its own results.
module mbox_handshake_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_code = '0;
    logic [31:0]  req_timeout = '0;
    logic [3:0]   req_argc = '0;
    logic [383:0] req_args = '0;
    logic [15:0]  poll_limit = 16'd8;
    logic         busy, done, hang_err;
    logic [511:0] rb_data;
    logic [15:0]  rb_mismatch;
    logic         bus_req, bus_we;
    logic [15:0]  bus_addr;
    logic [31:0]  bus_wdata;
    logic         bus_ack = 1'b0;
    logic [31:0]  bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // far-side model state
    logic [31:0] mem [16];
    int fw_delay = 0;
    int misses = 0;
    bit corrupt = 0;
    int ev_n = 0;
    bit ev_we [128];
    int ev_off [128];
    logic [31:0] ev_dat [128];
    int busy_viol = 0;
    int m_off;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_handshake_engine u_mbox_handshake_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .req_timeout(req_timeout), .req_argc(req_argc), .req_args(req_args),
        .poll_limit(poll_limit), .busy(busy), .done(done), .hang_err(hang_err),
        .rb_data(rb_data), .rb_mismatch(rb_mismatch), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // Far-side mailbox: one-cycle acknowledged word bus, completes after fw_delay misses.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
        end else if (bus_req && !bus_ack) begin
            if (!busy) busy_viol++;
            m_off = int'(bus_addr) - 'h44;
            if (m_off < 0 || m_off > 15) m_off = 15;
            if (ev_n < 128) begin
                ev_we[ev_n] = bus_we; ev_off[ev_n] = m_off; ev_dat[ev_n] = bus_wdata;
            end
            ev_n++;
            if (bus_we) begin
                mem[m_off] = bus_wdata;
                if (m_off == 0 && bus_wdata == 32'h3) misses = 0;
            end else if (m_off == 0 && mem[0] == 32'h3) begin
                if (misses >= fw_delay) begin
                    mem[0] = 32'h7;
                    if (corrupt) begin
                        mem[5] = mem[5] ^ 32'h1;
                        mem[2] = 32'h0000_ABCD;
                    end
                end else begin
                    misses++;
                end
            end
            bus_rdata <= mem[m_off];
            bus_ack   <= 1'b1;
        end else begin
            bus_ack <= 1'b0;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog act=%0d exp<%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] arg_word(input logic [31:0] code, input int k);
        return 32'hA500_0000 | (code[15:0] << 8) | 32'(k + 1);
    endfunction

    // One exchange: request, optional intruding request, wait, check.
    task automatic run_txn(input logic [31:0] code, input logic [31:0] tmo,
                           input int argc, input int fwd, input int lim,
                           input bit corr, input bit intrude, input string tag);
        int lim_eff, polls, exp_n, bad, wait_n;
        bit hang;
        logic [31:0] expw;
        for (int k = 0; k < 16; k++) mem[k] = 32'hDEAD_0000 | 32'(k);
        fw_delay = fwd; corrupt = corr; ev_n = 0; busy_viol = 0;
        lim_eff = (lim == 0) ? 1 : lim;
        hang = (fwd >= lim_eff);
        polls = hang ? lim_eff : fwd + 1;
        exp_n = 15 + polls + (hang ? 0 : 17);
        @(negedge clk);
        poll_limit = 16'(lim);
        req_code = code; req_timeout = tmo; req_argc = 4'(argc);
        for (int k = 0; k < 12; k++) req_args[k*32 +: 32] = arg_word(code, k);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {tag, " R9 busy after accept"}, busy, 1);
        if (intrude) begin
            repeat (3) @(negedge clk);
            req_code = 32'h0000_0BAD; req_argc = 4'd0; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(done == 1'b1, {tag, " R6 done seen"}, done, 1);
        chk(busy == 1'b0, {tag, " R9 busy low with done"}, busy, 0);
        chk(busy_viol == 0, {tag, " R9 busy over bus ops"}, busy_viol, 0);
        chk(hang_err == hang, {tag, " R8 hang_err"}, hang_err, hang);
        chk(ev_n == exp_n, {tag, " R4/R8 bus op count"}, ev_n, exp_n);
        // event order: R1 params, R3 flag, R4 polls, R5 readback, R6 clear
        bad = 0;
        for (int i = 0; i < ev_n && i < 128; i++) begin
            bit ew; int eo; logic [31:0] ed; bit chkd;
            chkd = 0; ed = '0;
            if (i < 14) begin ew = 1; eo = (i == 0) ? 1 : i + 2; end
            else if (i == 14) begin ew = 1; eo = 0; ed = 32'h3; chkd = 1; end
            else if (i < 15 + polls) begin ew = 0; eo = 0; end
            else if (i < 31 + polls) begin ew = 0; eo = i - 15 - polls; end
            else begin ew = 1; eo = 0; ed = 32'h0; chkd = 1; end
            if (ev_we[i] != ew || ev_off[i] != eo || (chkd && ev_dat[i] != ed)) bad++;
        end
        chk(bad == 0, {tag, " R1/R3/R5 bus op order"}, bad, 0);
        chk(mem[1] == code && mem[3] == tmo, {tag, " R1 code/timeout words"}, mem[1], code);
        chk(mem[2][31:16] == 16'hDEAD || (corr && mem[2] == 32'hABCD),
            {tag, " R1 return word untouched"}, mem[2], 32'hDEAD0002);
        bad = 0;
        for (int k = 0; k < 12; k++) begin
            expw = (k < argc) ? arg_word(code, k) : 32'h0;
            if (corr && k == 1) expw ^= 32'h1;
            if (mem[4+k] != expw) bad++;
        end
        chk(bad == 0, {tag, " R2 argument slots"}, bad, 0);
        if (hang) begin
            chk(mem[0] == 32'h3, {tag, " R8 flag left raised"}, mem[0], 3);
        end else begin
            chk(mem[0] == 32'h0, {tag, " R6 flag cleared"}, mem[0], 0);
            bad = 0;
            for (int k = 0; k < 16; k++) begin
                if (k == 0) expw = 32'h7;
                else if (k == 1) expw = code;
                else if (k == 2) expw = corr ? 32'h0000_ABCD : 32'hDEAD_0002;
                else if (k == 3) expw = tmo;
                else expw = (k - 4 < argc) ? arg_word(code, k - 4) : 32'h0;
                if (corr && k == 5) expw ^= 32'h1;
                if (rb_data[k*32 +: 32] != expw) bad++;
            end
            chk(bad == 0, {tag, " R5 readback words"}, bad, 0);
            chk(rb_mismatch == (corr ? 16'h0020 : 16'h0000), {tag, " R7 mismatch mask"},
                rb_mismatch, corr ? 16'h0020 : 16'h0000);
        end
        // R10: nothing further after the exchange
        exp_n = ev_n;
        repeat (10) @(negedge clk);
        chk(ev_n == exp_n && !busy, {tag, " R10 no follow-on exchange"}, ev_n, exp_n);
    endtask

    task automatic test_reset();
        chk(!busy && !done && !hang_err && !bus_req, "R9 reset state",
            {busy, done, hang_err, bus_req}, 0);
        chk(rb_mismatch == 16'h0, "R7 reset mask", rb_mismatch, 0);
    endtask

    task automatic test_full_args();   run_txn(32'h0000_00C1, 32'h0000_0100, 12, 1, 8, 0, 0, "full"); endtask
    task automatic test_partial_args(); run_txn(32'h0000_0042, 32'h0003_0000, 3, 0, 8, 0, 0, "partial"); endtask
    task automatic test_no_args();     run_txn(32'h0000_0007, 32'h0000_0010, 0, 2, 4, 0, 0, "noargs"); endtask
    task automatic test_limit_edge_ok(); run_txn(32'h0000_0051, 32'h0000_0020, 5, 2, 3, 0, 0, "edge_ok"); endtask
    task automatic test_limit_hang();  run_txn(32'h0000_0052, 32'h0000_0020, 5, 3, 3, 0, 0, "edge_hang"); endtask
    task automatic test_limit_zero();  run_txn(32'h0000_0053, 32'h0000_0020, 1, 5, 0, 0, 0, "lim_zero"); endtask
    task automatic test_mismatch();    run_txn(32'h0000_0060, 32'h0000_0030, 6, 1, 8, 1, 0, "mismatch"); endtask
    task automatic test_intrude();     run_txn(32'h0000_0070, 32'h0000_0040, 12, 1, 8, 0, 1, "intrude"); endtask
    task automatic test_after_hang();  run_txn(32'h0000_0080, 32'h0000_0050, 2, 0, 1, 0, 0, "recover"); endtask

    initial begin
        for (int k = 0; k < 16; k++) mem[k] = '0;
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_full_args();
        test_partial_args();
        test_no_args();
        test_limit_edge_ok();
        test_limit_hang();
        test_after_hang();
        test_limit_zero();
        test_mismatch();
        test_intrude();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule